// File: doc/BRIEF.md
# Dual-Mode Multiply-Accumulate Unit with Saturating Accumulator

This block is a fixed-point multiply-accumulate datapath. One signed multiplier array is split into four partial-product multipliers. Those multipliers either form a full signed 32x32 multiply, or they act as two independent signed 16x16 multipliers. In the dual mode, the upper halves of the two operands are multiplied together, and the lower halves are multiplied together. Either kind of multiply completes in the cycle in which the operands are presented. A registered 32-bit product word and a second registered 32-bit word hold the results.

On each valid cycle the accumulator is updated from the product path. That path carries a bidirectional shifter of 0 to 16 places. The update is one of four operations:

- load the shifted product;
- add it;
- subtract it;
- accumulate the shifted product word registered on the previous multiply, while the new product is captured.

The sum is formed with guard bits. With saturation on, it clamps to the most positive or most negative 32-bit value, and a sticky overflow flag records the clamp. With saturation off, the sum wraps. A second shifter of 0 to 16 places drives a shifted view of the accumulator. Software-side users address the 16-bit halves and the bytes of the product and accumulator words as bit slices of the outputs.

The unit has no control states beyond its registers. The operation code selects one of four named update transitions of the accumulator register: LOAD, ADD, SUB and ACCUM. A low valid holds every data register.

Top module: `fxmac_core`

## Requirements
- R1: After reset, prod_o, paux_o, acc_o, acc_sh_o and ovf_o are all zero.
- R2: With vld_i=1 and dual_i=0, the cycle after the edge shows the signed 64-bit product of a_i and b_i. When hisel_i=1, prod_o holds bits 63:32 and paux_o holds bits 31:0; when hisel_i=0, the two words are swapped.
- R3: With vld_i=1 and dual_i=1, prod_o becomes the signed product of a_i[31:16] and b_i[31:16], and paux_o becomes the signed product of a_i[15:0] and b_i[15:0]. In this mode hisel_i has no effect.
- R4: op_i=2'b00 (LOAD) sets acc_o to the shifted new prod_o word.
- R5: op_i=2'b01 (ADD) adds the shifted new prod_o word to acc_o, and op_i=2'b10 (SUB) subtracts it from acc_o.
- R6: op_i=2'b11 (ACCUM) adds the shifted prod_o value held before the edge to acc_o, while prod_o and paux_o take the new product.
- R7: The product shifter treats prod_o as a signed 32-bit value. With psh_rt_i=0 it shifts left, filling with zeros; with psh_rt_i=1 it shifts right arithmetically. It shifts by psh_amt_i places, and amounts above 16 act as 16. Bits shifted out to the left take part in the overflow test.
- R8: With sat_en_i=1, an exact result above 0x7FFFFFFF loads 0x7FFFFFFF, and one below -2^31 loads 0x80000000. With sat_en_i=0, the low 32 bits of the exact result are loaded.
- R9: ovf_o is set the cycle after a clamp occurs and stays set until ovf_clr_i is sampled high. When a clear and a clamp fall in the same cycle, the clamp wins.
- R10: With vld_i=0, prod_o, paux_o and acc_o hold their values whatever the other inputs are. ovf_clr_i still clears the flag.
- R11: acc_sh_o is acc_o shifted combinationally by ash_amt_i places: left when ash_rt_i=0, dropping bits above bit 31, and arithmetic right when ash_rt_i=1. Amounts above 16 act as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Perform a multiply and accumulator update this cycle |
| dual_i | input | 1 | 1: two 16x16 lanes; 0: one 32x32 multiply |
| hisel_i | input | 1 | In 32x32 mode, route the upper product word to prod_o |
| op_i | input | 2 | Accumulator update: 00 LOAD, 01 ADD, 10 SUB, 11 ACCUM |
| psh_amt_i | input | 5 | Product path shift amount (0-16, larger values act as 16) |
| psh_rt_i | input | 1 | Product path shift direction, 1 = right |
| ash_amt_i | input | 5 | Accumulator output shift amount |
| ash_rt_i | input | 1 | Accumulator output shift direction, 1 = right |
| sat_en_i | input | 1 | Clamp the accumulator on overflow |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| prod_o | output | 32 | Registered product word that feeds the accumulator |
| paux_o | output | 32 | Other product word, or low-lane product in dual mode |
| acc_o | output | 32 | Accumulator |
| acc_sh_o | output | 32 | Shifted view of the accumulator |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is an overflow that comes only from the product shifter. The product word itself fits in 32 bits, and only the left shift carries it past the accumulator range. A wrong guard width would hide this. The stimulus builds such words on purpose: a 32x32 multiply whose lower word is 0x70000000, or its negative, followed by a LOAD with a left shift of 4. This is run with saturation on and again with it off. After that, ADD steps push an already clamped accumulator past the limit again, a clear is issued in the same cycle as a clamp, and an ACCUM step follows a change of mode, so that the old product word and the new one differ.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
    // Accumulator update selected by the operation code
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_SUB   = 2'b10,
        OP_ACCUM = 2'b11
    } mac_op_e;
endpackage

// File: rtl/fxmac_mul.sv
// Shared signed multiplier array: four partial products that form either
// one 32x32 product or two independent 16x16 lane products.
module fxmac_mul #(
    parameter int W = 32
) (
    input  logic         dual_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int H  = W / 2;
    localparam int PW = W + 2;   // width of the partial products with a 17-bit factor

    logic signed [W-1:0]   ah_x, bh_x;
    logic signed [PW-1:0]  ah_y, bh_y, al_x, bl_x;
    logic signed [W-1:0]   pp_hh;
    logic signed [PW-1:0]  pp_ll, pp_hl, pp_lh;
    logic        [2*W-1:0] f_hh, f_ll, f_hl, f_lh, full;

    always_comb begin
        ah_x = {{H{a_i[W-1]}}, a_i[W-1:H]};
        bh_x = {{H{b_i[W-1]}}, b_i[W-1:H]};
        ah_y = {{(PW-H){a_i[W-1]}}, a_i[W-1:H]};
        bh_y = {{(PW-H){b_i[W-1]}}, b_i[W-1:H]};
        // low halves are signed in dual mode, unsigned digits in wide mode
        al_x = {{(PW-H){dual_i & a_i[H-1]}}, a_i[H-1:0]};
        bl_x = {{(PW-H){dual_i & b_i[H-1]}}, b_i[H-1:0]};

        pp_hh = ah_x * bh_x;
        pp_ll = al_x * bl_x;
        pp_hl = ah_y * bl_x;
        pp_lh = al_x * bh_y;

        f_hh = {{W{pp_hh[W-1]}}, pp_hh};
        f_ll = {{(2*W-PW){pp_ll[PW-1]}}, pp_ll};
        f_hl = {{(2*W-PW){pp_hl[PW-1]}}, pp_hl};
        f_lh = {{(2*W-PW){pp_lh[PW-1]}}, pp_lh};
        full = (f_hh << W) + (f_hl << H) + (f_lh << H) + f_ll;

        if (dual_i) begin
            hi_o = pp_hh;
            lo_o = pp_ll[W-1:0];
        end else begin
            hi_o = full[2*W-1:W];
            lo_o = full[W-1:0];
        end
    end

    // R2: the split array reproduces the full signed product
    always_comb begin
        if (!$isunknown({dual_i, a_i, b_i}) && !dual_i) begin
            a_r2_wide_product: assert ({hi_o, lo_o} ==
                ({{W{a_i[W-1]}}, a_i} * {{W{b_i[W-1]}}, b_i}));
        end
    end
endmodule

// File: rtl/fxmac_shift.sv
// Bidirectional shifter, 0..MAX places, left or arithmetic right,
// with optional sign extension to a wider output.
module fxmac_shift #(
    parameter int IW  = 32,
    parameter int OW  = 32,
    parameter int MAX = 16,
    parameter int AW  = 5
) (
    input  logic [IW-1:0] d_i,
    input  logic [AW-1:0] amt_i,
    input  logic          rt_i,
    output logic [OW-1:0] q_o
);
    logic signed [OW-1:0] ext;
    logic        [AW-1:0] eff;

    generate
        if (OW > IW) begin : g_widen
            assign ext = {{(OW-IW){d_i[IW-1]}}, d_i};
        end else begin : g_same
            assign ext = d_i[OW-1:0];
        end
    endgenerate

    always_comb begin
        eff = (amt_i > AW'(MAX)) ? AW'(MAX) : amt_i;
        if (rt_i) q_o = ext >>> eff;
        else      q_o = ext << eff;
    end

    // R7/R11: a zero amount passes the (sign-extended) value unchanged
    always_comb begin
        if (!$isunknown({d_i, amt_i, rt_i}) && amt_i == '0) begin
            a_r7_zero_shift: assert (q_o == ext);
        end
    end
endmodule

// File: rtl/fxmac_acc.sv
// Accumulator register with guard-bit sum, saturation and sticky flag.
module fxmac_acc
    import fxmac_pkg::*;
#(
    parameter int W  = 32,
    parameter int XW = 49
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  mac_op_e       op_i,
    input  logic [XW-1:0] term_i,
    input  logic          sat_en_i,
    input  logic          clr_i,
    output logic [W-1:0]  acc_o,
    output logic          ovf_o
);
    localparam int SW = XW + 1;
    localparam logic signed [SW-1:0] LIM_HI = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] LIM_LO = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic        [W-1:0]  acc_q, acc_d;
    logic                 ovf_q;
    logic signed [SW-1:0] acc_x, term_x, sum;
    logic                 over, under, evt;

    always_comb begin
        acc_x  = {{(SW-W){acc_q[W-1]}}, acc_q};
        term_x = {term_i[XW-1], term_i};
        unique case (op_i)
            OP_LOAD:  sum = term_x;
            OP_ADD:   sum = acc_x + term_x;
            OP_SUB:   sum = acc_x - term_x;
            OP_ACCUM: sum = acc_x + term_x;
            default:  sum = acc_x;
        endcase
        over  = sum > LIM_HI;
        under = sum < LIM_LO;
        evt   = en_i && sat_en_i && (over || under);
        if (sat_en_i && over)       acc_d = {1'b0, {(W-1){1'b1}}};
        else if (sat_en_i && under) acc_d = {1'b1, {(W-1){1'b0}}};
        else                        acc_d = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (en_i) acc_q <= acc_d;
            ovf_q <= (ovf_q && !clr_i) || evt;
        end
    end

    assign acc_o = acc_q;
    assign ovf_o = ovf_q;

    a_r8_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sat_en_i && over) |=> (acc_q == {1'b0, {(W-1){1'b1}}}));
    a_r8_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sat_en_i && under) |=> (acc_q == {1'b1, {(W-1){1'b0}}}));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(en_i && sat_en_i)) |=> !ovf_q);
    a_r8_no_flag_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_q && !(en_i && sat_en_i)) |=> !ovf_q);
    a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_q));
endmodule

// File: rtl/fxmac_core.sv
// Dual-mode multiply-accumulate unit, top level.
module fxmac_core
    import fxmac_pkg::*;
#(
    parameter int W      = 32,
    parameter int SH_MAX = 16,
    parameter int AW     = $clog2(SH_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic          dual_i,
    input  logic          hisel_i,
    input  logic [1:0]    op_i,
    input  logic [AW-1:0] psh_amt_i,
    input  logic          psh_rt_i,
    input  logic [AW-1:0] ash_amt_i,
    input  logic          ash_rt_i,
    input  logic          sat_en_i,
    input  logic          ovf_clr_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  prod_o,
    output logic [W-1:0]  paux_o,
    output logic [W-1:0]  acc_o,
    output logic [W-1:0]  acc_sh_o,
    output logic          ovf_o
);
    localparam int H  = W / 2;
    localparam int XW = W + SH_MAX + 1;

    mac_op_e      op;
    logic [W-1:0] mul_hi, mul_lo, new_prod, new_aux, shift_src;
    logic [W-1:0] prod_q, aux_q;
    logic [XW-1:0] term;

    assign op = mac_op_e'(op_i);

    fxmac_mul #(.W(W)) u_mul (
        .dual_i (dual_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .hi_o   (mul_hi),
        .lo_o   (mul_lo)
    );

    // word routing into the product registers
    always_comb begin
        if (dual_i || hisel_i) begin
            new_prod = mul_hi;
            new_aux  = mul_lo;
        end else begin
            new_prod = mul_lo;
            new_aux  = mul_hi;
        end
        unique case (op)
            OP_ACCUM: shift_src = prod_q;
            default:  shift_src = new_prod;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            aux_q  <= '0;
        end else if (vld_i) begin
            prod_q <= new_prod;
            aux_q  <= new_aux;
        end
    end

    fxmac_shift #(.IW(W), .OW(XW), .MAX(SH_MAX), .AW(AW)) u_psh (
        .d_i   (shift_src),
        .amt_i (psh_amt_i),
        .rt_i  (psh_rt_i),
        .q_o   (term)
    );

    fxmac_acc #(.W(W), .XW(XW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (vld_i),
        .op_i     (op),
        .term_i   (term),
        .sat_en_i (sat_en_i),
        .clr_i    (ovf_clr_i),
        .acc_o    (acc_o),
        .ovf_o    (ovf_o)
    );

    fxmac_shift #(.IW(W), .OW(W), .MAX(SH_MAX), .AW(AW)) u_ash (
        .d_i   (acc_o),
        .amt_i (ash_amt_i),
        .rt_i  (ash_rt_i),
        .q_o   (acc_sh_o)
    );

    assign prod_o = prod_q;
    assign paux_o = aux_q;

    a_r10_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(prod_q) && $stable(aux_q)));
    a_r3_dual_hi_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dual_i) |=> ($signed(prod_q) ==
            $signed({{H{$past(a_i[W-1])}}, $past(a_i[W-1:H])}) *
            $signed({{H{$past(b_i[W-1])}}, $past(b_i[W-1:H])})));
    a_r3_dual_lo_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dual_i) |=> ($signed(aux_q) ==
            $signed({{H{$past(a_i[H-1])}}, $past(a_i[H-1:0])}) *
            $signed({{H{$past(b_i[H-1])}}, $past(b_i[H-1:0])})));
endmodule

// File: tb/fxmac_core_bench.sv
module fxmac_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vld_i, dual_i, hisel_i, psh_rt_i, ash_rt_i, sat_en_i, ovf_clr_i;
    logic [1:0]  op_i;
    logic [4:0]  psh_amt_i, ash_amt_i;
    logic [31:0] a_i, b_i;
    logic [31:0] prod_o, paux_o, acc_o, acc_sh_o;
    logic        ovf_o;

    always #10 clk = ~clk;   // 50 MHz

    fxmac_core u_fxmac_core (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .dual_i(dual_i), .hisel_i(hisel_i),
        .op_i(op_i), .psh_amt_i(psh_amt_i), .psh_rt_i(psh_rt_i),
        .ash_amt_i(ash_amt_i), .ash_rt_i(ash_rt_i), .sat_en_i(sat_en_i),
        .ovf_clr_i(ovf_clr_i), .a_i(a_i), .b_i(b_i), .prod_o(prod_o),
        .paux_o(paux_o), .acc_o(acc_o), .acc_sh_o(acc_sh_o), .ovf_o(ovf_o)
    );

    typedef struct {
        logic [31:0] prod, aux, acc, accsh;
        logic        ovf;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0, errors = 0;
    logic [31:0] m_prod = '0, m_aux = '0, m_acc = '0;
    logic        m_ovf = 1'b0;

    function automatic longint prod_shift(logic [31:0] v, logic [4:0] amt, logic rt);
        int n = (amt > 5'd16) ? 16 : int'(amt);
        longint x = longint'($signed(v));
        return rt ? (x >>> n) : (x << n);
    endfunction

    function automatic logic [31:0] acc_shift(logic [31:0] v, logic [4:0] amt, logic rt);
        int n = (amt > 5'd16) ? 16 : int'(amt);
        logic signed [31:0] x = v;
        return rt ? (x >>> n) : (x << n);
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic v, input logic dl, input logic hs, input logic [1:0] op,
                        input logic [4:0] pa, input logic pr, input logic [4:0] aa,
                        input logic ar, input logic se, input logic clr,
                        input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t   e;
        longint full, ph, pl, term, s, acc_old;
        logic [31:0] np, na, src;
        logic   evt;
        @(negedge clk);
        vld_i = v; dual_i = dl; hisel_i = hs; op_i = op; psh_amt_i = pa; psh_rt_i = pr;
        ash_amt_i = aa; ash_rt_i = ar; sat_en_i = se; ovf_clr_i = clr; a_i = a; b_i = b;
        evt = 1'b0;
        if (v) begin
            if (dl) begin
                ph = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
                pl = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                np = ph[31:0];
                na = pl[31:0];
            end else begin
                full = longint'($signed(a)) * longint'($signed(b));
                np = hs ? full[63:32] : full[31:0];
                na = hs ? full[31:0]  : full[63:32];
            end
            src     = (op == 2'b11) ? m_prod : np;
            term    = prod_shift(src, pa, pr);
            acc_old = longint'($signed(m_acc));
            case (op)
                2'b00:   s = term;
                2'b10:   s = acc_old - term;
                default: s = acc_old + term;
            endcase
            if (se && s > 64'sd2147483647) begin
                m_acc = 32'h7FFF_FFFF; evt = 1'b1;
            end else if (se && s < -64'sd2147483648) begin
                m_acc = 32'h8000_0000; evt = 1'b1;
            end else begin
                m_acc = s[31:0];
            end
            m_prod = np;
            m_aux  = na;
        end
        m_ovf   = (m_ovf && !clr) || evt;
        e.prod  = m_prod;
        e.aux   = m_aux;
        e.acc   = m_acc;
        e.accsh = acc_shift(m_acc, aa, ar);
        e.ovf   = m_ovf;
        e.req   = req;
        sbq.push_back(e);
    endtask

    // monitor: compares after each edge, away from the edge
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (prod_o !== e.prod || paux_o !== e.aux || acc_o !== e.acc ||
                acc_sh_o !== e.accsh || ovf_o !== e.ovf) begin
                errors++;
                $display("FAIL %s: got prod=%h aux=%h acc=%h accsh=%h ovf=%b exp prod=%h aux=%h acc=%h accsh=%h ovf=%b",
                         e.req, prod_o, paux_o, acc_o, acc_sh_o, ovf_o,
                         e.prod, e.aux, e.acc, e.accsh, e.ovf);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        rst_n = 1'b0; vld_i = 0; dual_i = 0; hisel_i = 0; op_i = 0; psh_amt_i = 0;
        psh_rt_i = 0; ash_amt_i = 0; ash_rt_i = 0; sat_en_i = 0; ovf_clr_i = 0;
        a_i = 0; b_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if ({prod_o, paux_o, acc_o, acc_sh_o, ovf_o} !== '0) begin
            errors++;
            $display("FAIL R1: got prod=%h aux=%h acc=%h accsh=%h ovf=%b exp all zero",
                     prod_o, paux_o, acc_o, acc_sh_o, ovf_o);
        end

        // R2: wide mode, both word selections, positive and negative
        step(1,0,1,2'b00,0,0,0,0,0,0,32'h1234_5678,32'h9ABC_DEF0,"R2 upper word");
        step(1,0,0,2'b00,0,0,0,0,0,0,32'h1234_5678,32'h9ABC_DEF0,"R2 lower word");
        step(1,0,1,2'b00,0,0,0,0,0,0,32'hFFFF_FFFD,32'h0000_0007,"R2 negative upper");
        step(1,0,0,2'b00,0,0,0,0,0,0,32'h8000_0000,32'h8000_0000,"R2 most negative");
        // R3: dual lanes, hisel ignored
        step(1,1,0,2'b00,0,0,0,0,0,0,32'h8000_0003,32'h8000_FFFE,"R3 dual lanes");
        step(1,1,1,2'b00,0,0,0,0,0,0,32'h7FFF_8000,32'hFFFF_7FFF,"R3 dual hisel ignored");
        // R4/R7: load with left shift and clamped right shift
        step(1,0,0,2'b00,4,0,0,0,0,0,32'h0000_0100,32'h0000_0001,"R4 load shl4");
        step(1,0,0,2'b00,20,1,0,0,0,0,32'hFFF0_0000,32'h0000_0003,"R7 shr amount clamps to 16");
        step(1,0,0,2'b00,16,0,0,0,0,0,32'h0000_0003,32'h0000_0005,"R7 shl16");
        // R5: add and subtract
        step(1,0,0,2'b01,2,0,0,0,1,0,32'h0000_0010,32'h0000_0010,"R5 add");
        step(1,1,0,2'b10,1,1,0,0,1,0,32'h0004_0000,32'h0005_0000,"R5 sub");
        // R6: accumulate previous product word after a mode change
        step(1,0,1,2'b11,3,0,0,0,1,0,32'h0000_0009,32'h0000_0009,"R6 accum old word");
        step(1,0,0,2'b11,0,0,0,0,1,0,32'h0000_0002,32'h0000_0002,"R6 accum chain");
        // R8/R9: overflow reached only through the shifter
        step(1,0,0,2'b00,4,0,0,0,0,0,32'h1000_0000,32'h0000_0007,"R8 wrap when off");
        step(1,0,0,2'b00,4,0,0,0,1,0,32'h1000_0000,32'h0000_0007,"R8 clamp positive");
        step(1,0,0,2'b01,0,0,0,0,1,0,32'h0000_0001,32'h0000_0001,"R8 clamp again on add");
        step(1,0,0,2'b00,0,0,0,0,1,0,32'h0000_0002,32'h0000_0003,"R9 flag sticks");
        step(1,0,0,2'b00,0,0,0,0,1,1,32'h0000_0002,32'h0000_0003,"R9 clear");
        step(1,0,0,2'b00,4,0,0,0,1,1,32'hF000_0000,32'h0000_0007,"R9 clamp wins over clear");
        step(1,0,0,2'b00,0,0,0,0,0,0,32'h0000_0001,32'h0000_0001,"R9 flag kept without sat");
        // R10: hold with changing inputs, clear still acts
        step(0,1,1,2'b01,9,0,0,0,1,0,32'hDEAD_BEEF,32'hCAFE_F00D,"R10 hold");
        step(0,0,0,2'b10,4,0,0,0,1,1,32'h7FFF_FFFF,32'h7FFF_FFFF,"R10 hold clear acts");
        // R11: accumulator output shifter
        step(1,0,0,2'b00,0,0,4,1,0,0,32'hFFFF_F000,32'h0000_0011,"R11 acc shr4");
        step(0,0,0,2'b00,0,0,8,0,0,0,32'h0,32'h0,"R11 acc shl8");
        step(0,0,0,2'b00,0,0,31,1,0,0,32'h0,32'h0,"R11 acc shr clamp");
        // mixed patterns
        seed = 32'h1ACE_B00C;
        for (int i = 0; i < 48; i++) begin
            logic [31:0] ra, rb;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; ra = seed;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; rb = seed;
            step(1, ra[0], ra[1], rb[1:0], rb[6:2], ra[2], ra[8:4], rb[7], rb[8], ra[9] & ra[10],
                 ra, rb, "R5 R6 R8 mixed");
        end
        step(0,0,0,2'b00,0,0,0,0,0,0,32'h0,32'h0,"R10 final hold");
        repeat (3) @(posedge clk);
        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule